// File: doc/BRIEF.md
# Complementary PWM Generator with Filtered Fault Shutdown

This block drives three complementary output pairs (six lines) from one shared 15-bit counter. The counter runs in one of two ways. In edge mode it counts up and wraps. In center mode it counts up to the period and back down. Each pair compares the counter against its own duty value to form a high-side demand. The low side is the complement of that demand, with one clock in which both sides are low at every switch. Instead of the internal compare, any pair can take its demand from an external override input.

The period and duty values are written into buffer registers. They are copied into the working registers only at a reload point, and only if a load-permit bit is armed. While the counter is stopped, every cycle counts as a reload point.

Four fault inputs each pass through a stable-sample filter with a programmable length. A filtered fault sets a sticky flag. Each flag can be mapped to any of the pairs, and while it is set it forces both lines of those pairs low. Software clears a flag by writing to a clear register. The clear takes effect only once the filtered fault has gone away.

Top module: `cpwm_top`

## Requirements
- R1: While rst_ni is low, all six outputs and all four fault flags are 0.
- R2: Edge mode (control bit1=0, bit0=1 run). The counter steps 0..P-1 and wraps, so each period lasts P cycles. For a period P and duty D with 2<=D<=P-1, the high output of a pair (pwm_o[2p]) is 1 for D-1 cycles per period and the low output (pwm_o[2p+1]) for P-D-1 cycles.
- R3: Center mode (control bit1=1). The counter steps 0..P..1, so each period lasts 2P cycles. The high output is 1 for 2D-2 cycles per period and the low output for 2P-2D cycles.
- R4: A write to the period buffer (address 1) or a duty buffer (address 2+p) changes nothing until a reload point occurs while load-permit is armed. Load-permit is armed by writing control (address 0) with bit2=1.
- R5: Load-permit disarms itself at the reload that transfers the buffers, so a later buffer write with no new arm has no effect.
- R6: Fault k is taken as active only after fault_i[k] has differed from its filtered level for N consecutive samples. N = 1 + the field at bits [3k+2:3k] of address 5. A shorter pulse sets no flag.
- R7: When fault flag k is 1 and map bit 3k+p (address 6) is 1, both outputs of pair p are 0 from the next clock. Unmapped pairs keep running.
- R8: A fault flag stays 1 until a write to address 8 with bit k=1 occurs while the filtered fault is inactive. A clear written while the fault is still active has no effect.
- R9: With source bit p (address 7) set, the demand of pair p is ovr_i[p] instead of the compare result.
- R10: The two outputs of a pair are never 1 together, and an output rises only after a cycle in which its partner was 0.
- R11: While stopped (control bit0=0), unfaulted pairs in generator mode hold high=0 and low=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 16 | Register write data |
| fault_i | input | 4 | Fault inputs, active high, synchronous to clk_i |
| ovr_i | input | 3 | External demand per pair |
| pwm_o | output | 6 | Pair p: high side at bit 2p, low side at bit 2p+1 |
| fault_flag_o | output | 4 | Sticky fault flags |

## Verification
Several events can land in the same clock cycle. A fault flag can set in the cycle where a pair would otherwise switch sides. A load-permit arm can coincide with a reload. A flag clear can arrive while the filter still reports the fault. The constrained random phase provokes these collisions with frequent writes to every register, short periods and fault lines that toggle often. A cycle-by-cycle bench model judges each cycle's six outputs and four flags, so any disagreement over which event wins in that cycle shows up as a mismatch.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_PERIOD = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_DUTY0  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_FLEN   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_FMAP   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_SRC    = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_FCLR   = 4'd8;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CTR  = 1;
  localparam int CTRL_LDOK = 2;
endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int N_PAIRS = 3,
  parameter int N_FLT   = 4,
  parameter int FLEN_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                wr_en_i,
  input  logic [ADDR_W-1:0]                   wr_addr_i,
  input  logic [DATA_W-1:0]                   wr_data_i,
  input  logic                                reload_i,
  output logic                                run_o,
  output logic                                center_o,
  output logic [CNT_W-1:0]                    period_o,
  output logic [N_PAIRS-1:0][CNT_W-1:0]       duty_o,
  output logic [N_FLT-1:0][FLEN_W-1:0]        flen_o,
  output logic [N_FLT-1:0][N_PAIRS-1:0]       fmap_o,
  output logic [N_PAIRS-1:0]                  src_o,
  output logic [N_FLT-1:0]                    fclr_o
);
  logic                          run_q, ctr_q, ldok_q;
  logic [CNT_W-1:0]              per_b_q, per_q;
  logic [N_PAIRS-1:0][CNT_W-1:0] duty_b_q, duty_q;
  logic [N_FLT-1:0][FLEN_W-1:0]  flen_q;
  logic [N_FLT-1:0][N_PAIRS-1:0] fmap_q;
  logic [N_PAIRS-1:0]            src_q;
  logic [N_PAIRS-1:0]            hit_duty;
  logic                          hit_ctrl, ldok_set, xfer;
  logic                          unused_data;

  assign unused_data = ^wr_data_i;
  assign hit_ctrl = wr_en_i && (wr_addr_i == ADR_CTRL);
  assign ldok_set = hit_ctrl && wr_data_i[CTRL_LDOK];
  assign xfer     = reload_i && ldok_q;

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_duty_dec
    localparam logic [ADDR_W-1:0] ADR_P = ADR_DUTY0 + ADDR_W'(p);
    assign hit_duty[p] = wr_en_i && (wr_addr_i == ADR_P);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      ctr_q    <= 1'b0;
      ldok_q   <= 1'b0;
      per_b_q  <= '0;
      per_q    <= '0;
      duty_b_q <= '0;
      duty_q   <= '0;
      flen_q   <= '0;
      fmap_q   <= '0;
      src_q    <= '0;
    end else begin
      if (hit_ctrl) begin
        run_q <= wr_data_i[CTRL_RUN];
        ctr_q <= wr_data_i[CTRL_CTR];
      end
      ldok_q <= (ldok_q && !reload_i) || ldok_set;
      if (wr_en_i && wr_addr_i == ADR_PERIOD) per_b_q <= wr_data_i[CNT_W-1:0];
      for (int p = 0; p < N_PAIRS; p++)
        if (hit_duty[p]) duty_b_q[p] <= wr_data_i[CNT_W-1:0];
      if (xfer) begin
        per_q  <= per_b_q;
        duty_q <= duty_b_q;
      end
      if (wr_en_i && wr_addr_i == ADR_FLEN) flen_q <= wr_data_i[N_FLT*FLEN_W-1:0];
      if (wr_en_i && wr_addr_i == ADR_FMAP) fmap_q <= wr_data_i[N_FLT*N_PAIRS-1:0];
      if (wr_en_i && wr_addr_i == ADR_SRC)  src_q  <= wr_data_i[N_PAIRS-1:0];
    end
  end

  assign fclr_o   = (wr_en_i && wr_addr_i == ADR_FCLR) ? wr_data_i[N_FLT-1:0] : '0;
  assign run_o    = run_q;
  assign center_o = ctr_q;
  assign period_o = per_q;
  assign duty_o   = duty_q;
  assign flen_o   = flen_q;
  assign fmap_o   = fmap_q;
  assign src_o    = src_q;

  // R4: working values move only on an armed reload
  a_r4_hold_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reload_i && ldok_q) |=> ($stable(per_q) && $stable(duty_q)));
  // R5: permit disarms after the transfer
  a_r5_ldok_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_i && ldok_q && !ldok_set) |=> !ldok_q);
endmodule

// File: rtl/cpwm_counter.sv
module cpwm_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reload_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d, reload;
  logic             edge_wrap;

  assign edge_wrap = ({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, period_i};

  always_comb begin
    cnt_d  = '0;
    up_d   = 1'b1;
    reload = 1'b0;
    if (!run_i) begin
      reload = 1'b1;
    end else if (!center_i) begin
      if (edge_wrap) reload = 1'b1;
      else           cnt_d  = cnt_q + ONE;
    end else if (up_q && cnt_q < period_i) begin
      cnt_d = cnt_q + ONE;
    end else if (cnt_q <= ONE) begin
      reload = 1'b1;                    // bottom of the down slope
    end else begin
      cnt_d = cnt_q - ONE;
      up_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload;

  a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= period_i);
  a_r11_stop_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/cpwm_fault_filter.sv
module cpwm_fault_filter #(
  parameter int FLEN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic [FLEN_W-1:0] len_i,
  input  logic              clr_i,
  output logic              flag_o
);
  logic              filt_q, filt_d, flag_q, flag_d;
  logic [FLEN_W-1:0] run_q, run_d;

  always_comb begin
    filt_d = filt_q;
    run_d  = '0;
    if (fault_i != filt_q) begin
      if (run_q >= len_i) filt_d = fault_i;   // len_i+1 equal samples seen
      else                run_d  = run_q + FLEN_W'(1);
    end
    flag_d = (flag_q && !clr_i) || filt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      run_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      filt_q <= filt_d;
      run_q  <= run_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  a_r6_filt_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(filt_q) |-> $past(fault_i));
  a_r8_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/cpwm_pair_out.sv
module cpwm_pair_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic demand_i,
  input  logic fault_i,
  output logic hi_o,
  output logic lo_o
);
  logic hi_q, lo_q;

  // a side turns on only once its partner is already off: one idle clock per switch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (fault_i) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (demand_i) begin
      hi_q <= !lo_q;
      lo_q <= 1'b0;
    end else begin
      hi_q <= 1'b0;
      lo_q <= !hi_q;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  a_r7_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |=> (!hi_q && !lo_q));
  a_r10_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_q && lo_q));
  a_r10_hi_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_q) |-> !$past(lo_q));
  a_r10_lo_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_q) |-> !$past(hi_q));
endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter int N_PAIRS = 3,
  parameter int N_FLT   = 4,
  parameter int FLEN_W  = 3,
  parameter int DATA_W  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [N_FLT-1:0]       fault_i,
  input  logic [N_PAIRS-1:0]     ovr_i,
  output logic [2*N_PAIRS-1:0]   pwm_o,
  output logic [N_FLT-1:0]       fault_flag_o
);
  logic                          run, center, reload;
  logic [CNT_W-1:0]              period, cnt;
  logic [N_PAIRS-1:0][CNT_W-1:0] duty;
  logic [N_FLT-1:0][FLEN_W-1:0]  flen;
  logic [N_FLT-1:0][N_PAIRS-1:0] fmap;
  logic [N_PAIRS-1:0]            src, demand, pair_flt;
  logic [N_FLT-1:0]              fclr, flags;

  cpwm_regs #(
    .CNT_W(CNT_W), .N_PAIRS(N_PAIRS), .N_FLT(N_FLT), .FLEN_W(FLEN_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .reload_i(reload), .run_o(run), .center_o(center), .period_o(period),
    .duty_o(duty), .flen_o(flen), .fmap_o(fmap), .src_o(src), .fclr_o(fclr)
  );

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .center_i(center), .period_i(period),
    .cnt_o(cnt), .reload_o(reload)
  );

  for (genvar k = 0; k < N_FLT; k++) begin : g_flt
    cpwm_fault_filter #(.FLEN_W(FLEN_W)) u_filt (
      .clk_i, .rst_ni, .fault_i(fault_i[k]), .len_i(flen[k]),
      .clr_i(fclr[k]), .flag_o(flags[k])
    );
  end

  always_comb begin
    pair_flt = '0;
    for (int p = 0; p < N_PAIRS; p++)
      for (int k = 0; k < N_FLT; k++)
        if (flags[k] && fmap[k][p]) pair_flt[p] = 1'b1;
  end

  for (genvar p = 0; p < N_PAIRS; p++) begin : g_pair
    assign demand[p] = src[p] ? ovr_i[p] : (run && (cnt < duty[p]));
    cpwm_pair_out u_out (
      .clk_i, .rst_ni, .demand_i(demand[p]), .fault_i(pair_flt[p]),
      .hi_o(pwm_o[2*p]), .lo_o(pwm_o[2*p+1])
    );
    // R9: an overridden, unfaulted pair follows its override within two clocks
    a_r9_override_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src[p] && !pair_flt[p] && ovr_i[p] && pwm_o[2*p]) |=> pwm_o[2*p] || pair_flt[p] || !ovr_i[p] || !src[p]);
  end

  assign fault_flag_o = flags;
endmodule

// File: tb/cpwm_top_tb.sv
module cpwm_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  fault = '0;
  logic [2:0]  ovr = '0;
  logic [5:0]  pwm;
  logic [3:0]  flag;

  int    n_chk = 0, n_bad = 0;
  bit    done = 0, cmp_en = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .fault_i(fault), .ovr_i(ovr), .pwm_o(pwm), .fault_flag_o(flag)
  );

  // ---------------- cycle model built from the requirements ----------------
  bit m_run, m_ctr, m_ldok, m_up;
  int m_perb, m_per, m_cnt;
  int m_dutb[3], m_duty[3];
  int m_flen[4], m_fc[4];
  bit m_filt[4], m_flag[4];
  bit m_map[4][3];
  bit m_src[3], m_hi[3], m_lo[3];

  function automatic logic [5:0] exp_pwm();
    logic [5:0] v;
    for (int p = 0; p < 3; p++) begin v[2*p] = m_hi[p]; v[2*p+1] = m_lo[p]; end
    return v;
  endfunction

  function automatic logic [3:0] exp_flag();
    logic [3:0] v;
    for (int k = 0; k < 4; k++) v[k] = m_flag[k];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_ctr = 0; m_ldok = 0; m_up = 1; m_perb = 0; m_per = 0; m_cnt = 0;
      for (int p = 0; p < 3; p++) begin
        m_dutb[p] = 0; m_duty[p] = 0; m_src[p] = 0; m_hi[p] = 0; m_lo[p] = 0;
      end
      for (int k = 0; k < 4; k++) begin
        m_flen[k] = 0; m_fc[k] = 0; m_filt[k] = 0; m_flag[k] = 0;
        for (int p = 0; p < 3; p++) m_map[k][p] = 0;
      end
    end else begin
      bit rl, nup, nfilt, clr;
      int ncnt;
      bit nhi[3], nlo[3];
      rl = 0; nup = 1; ncnt = 0;
      if (!m_run) rl = 1;
      else if (!m_ctr) begin
        if (m_cnt + 1 >= m_per) rl = 1; else ncnt = m_cnt + 1;
      end else if (m_up && m_cnt < m_per) ncnt = m_cnt + 1;
      else if (m_cnt <= 1) rl = 1;
      else begin ncnt = m_cnt - 1; nup = 0; end
      for (int p = 0; p < 3; p++) begin
        bit d, pf;
        pf = 0;
        for (int k = 0; k < 4; k++) if (m_flag[k] && m_map[k][p]) pf = 1;
        d = m_src[p] ? ovr[p] : (m_run && m_cnt < m_duty[p]);
        if (pf) begin nhi[p] = 0; nlo[p] = 0; end
        else if (d) begin nhi[p] = !m_lo[p]; nlo[p] = 0; end
        else begin nhi[p] = 0; nlo[p] = !m_hi[p]; end
      end
      for (int k = 0; k < 4; k++) begin
        nfilt = m_filt[k];
        if (fault[k] != m_filt[k]) begin
          if (m_fc[k] >= m_flen[k]) begin nfilt = fault[k]; m_fc[k] = 0; end
          else m_fc[k] = m_fc[k] + 1;
        end else m_fc[k] = 0;
        clr = wr_en && wr_addr == 4'd8 && wr_data[k];
        m_flag[k] = (m_flag[k] && !clr) || nfilt;
        m_filt[k] = nfilt;
      end
      if (rl && m_ldok) begin
        m_per = m_perb;
        for (int p = 0; p < 3; p++) m_duty[p] = m_dutb[p];
      end
      m_ldok = (m_ldok && !rl) || (wr_en && wr_addr == 4'd0 && wr_data[2]);
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin m_run = wr_data[0]; m_ctr = wr_data[1]; end
          4'd1: m_perb = int'(wr_data[14:0]);
          4'd2, 4'd3, 4'd4: m_dutb[int'(wr_addr) - 2] = int'(wr_data[14:0]);
          4'd5: for (int k = 0; k < 4; k++) m_flen[k] = int'(wr_data[3*k +: 3]);
          4'd6: for (int k = 0; k < 4; k++) for (int p = 0; p < 3; p++) m_map[k][p] = wr_data[3*k+p];
          4'd7: for (int p = 0; p < 3; p++) m_src[p] = wr_data[p];
          default: ;
        endcase
      end
      m_cnt = ncnt; m_up = nup;
      for (int p = 0; p < 3; p++) begin m_hi[p] = nhi[p]; m_lo[p] = nlo[p]; end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      check(pwm == exp_pwm(), tag, int'(pwm), int'(exp_pwm()));
      check(flag == exp_flag(), tag, int'(flag), int'(exp_flag()));
      for (int p = 0; p < 3; p++)
        check(!(pwm[2*p] && pwm[2*p+1]), "R10", int'(pwm[2*p+:2]), 0);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_bit(input int b, input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); c += int'(pwm[b]); end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    int c;
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    check(pwm == 6'b0, "R1", int'(pwm), 0);
    check(flag == 4'b0, "R1", int'(flag), 0);
    rst_n = 1;
    cmp_en = 1;
    idle(3);
    // R11: stopped after reset
    tag = "R11";
    check(pwm == 6'b101010, "R11", int'(pwm), 'h2a);

    // R2: edge mode P=10, D=4/2/8
    tag = "R2";
    wr(4'd1, 16'd10); wr(4'd2, 16'd4); wr(4'd3, 16'd2); wr(4'd4, 16'd8);
    wr(4'd0, 16'b100);
    wr(4'd0, 16'b001);
    idle(30);
    count_bit(0, 50, c); check(c == 15, "R2", c, 15);
    count_bit(1, 50, c); check(c == 25, "R2", c, 25);
    count_bit(4, 50, c); check(c == 35, "R2", c, 35);

    // R4: buffer write without arm has no effect, then arm
    tag = "R4";
    wr(4'd2, 16'd7);
    idle(25);
    count_bit(0, 50, c); check(c == 15, "R4", c, 15);
    wr(4'd0, 16'b101);
    idle(25);
    count_bit(0, 50, c); check(c == 30, "R4", c, 30);

    // R5: arm consumed, new buffer value stays parked
    tag = "R5";
    wr(4'd2, 16'd2);
    idle(25);
    count_bit(0, 50, c); check(c == 30, "R5", c, 30);

    // R11: stop
    tag = "R11";
    wr(4'd0, 16'b000);
    idle(4);
    check(pwm == 6'b101010, "R11", int'(pwm), 'h2a);

    // R3: center mode P=8, D=3 (pair0), D=2 (pair1)
    tag = "R3";
    wr(4'd1, 16'd8); wr(4'd2, 16'd3);
    wr(4'd0, 16'b110);
    wr(4'd0, 16'b011);
    idle(40);
    count_bit(0, 48, c); check(c == 12, "R3", c, 12);
    count_bit(1, 48, c); check(c == 30, "R3", c, 30);

    // R6: filter N=3 on fault0, map fault0->pair0, fault1->pair1,pair2
    tag = "R6";
    wr(4'd5, 16'd2);
    wr(4'd6, 16'h0031);
    @(negedge clk); fault[0] = 1;
    idle(2); fault[0] = 0;
    idle(4);
    check(flag[0] == 1'b0, "R6", int'(flag), 0);
    fault[0] = 1;
    idle(4);
    check(flag[0] == 1'b1, "R6", int'(flag), 1);

    // R7: pair0 forced off, pair1 keeps running
    tag = "R7";
    c = 0;
    repeat (16) begin @(negedge clk); c += int'(pwm[1:0] != 2'b00); end
    check(c == 0, "R7", c, 0);
    count_bit(2, 16, c); check(c == 2, "R7", c, 2);

    // R8: clear while active ignored, sticky after release, clear works
    tag = "R8";
    wr(4'd8, 16'h1);
    idle(2);
    check(flag[0] == 1'b1, "R8", int'(flag), 1);
    fault[0] = 0;
    idle(6);
    check(flag[0] == 1'b1, "R8", int'(flag), 1);
    wr(4'd8, 16'h1);
    idle(1);
    check(flag[0] == 1'b0, "R8", int'(flag), 0);

    // R9: override on pair2
    tag = "R9";
    wr(4'd7, 16'b100);
    ovr[2] = 1; idle(5);
    check(pwm[5:4] == 2'b01, "R9", int'(pwm[5:4]), 1);
    ovr[2] = 0; idle(4);
    check(pwm[5:4] == 2'b10, "R9", int'(pwm[5:4]), 2);

    // random mix, judged cycle by cycle against the model
    tag = "R4";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      wr_en = 0;
      if ($urandom_range(0, 5) == 0) begin
        int a;
        a = $urandom_range(0, 8);
        wr_en = 1; wr_addr = 4'(a);
        case (a)
          1: wr_data = 16'($urandom_range(0, 12));
          2, 3, 4: wr_data = 16'($urandom_range(0, 14));
          0: wr_data = 16'($urandom_range(0, 7));
          default: wr_data = 16'($urandom);
        endcase
      end
      for (int k = 0; k < 4; k++) if ($urandom_range(0, 5) == 0) fault[k] = ~fault[k];
      if ($urandom_range(0, 3) == 0) ovr = 3'($urandom);
    end
    @(negedge clk); wr_en = 0;
    idle(2);
    finish_run();
  end
endmodule